// File: doc/BRIEF.md
# Timer Clock-Select Prescaler

This block decides when a timer counter may advance. Every system clock cycle it drives a one-cycle count-enable pulse, `tick_o`, that the timer's counter uses as its increment enable. It is not a derived clock. A 3-bit select code picks the source of these pulses:

- nothing (the timer is halted),
- every system clock,
- one of four taps of a free-running 10-bit system-clock divider, or
- falling or rising edges of an asynchronous external pin.

The external pin passes through a two-flop synchronizer. A third flop follows it and acts as an edge detector, so each pin edge yields exactly one pulse. The select code is sampled on every clock edge. It has no handshake: it is plain control, and there is no data stream to apply back-pressure to.

Top module: `tmr_clk_prescaler`

## Requirements
- R1: With `sel_i` = 3'b000, `tick_o` stays low, so the timer is halted.
- R2: With `sel_i` = 3'b001, `tick_o` is high on every cycle.
- R3: Codes 3'b010, 3'b011, 3'b100 and 3'b101 select division by 8, 64, 256 and 1024. The divider counts up by one each cycle, starting from 0 at reset and wrapping at 1023. `tick_o` is high in the cycle after the divider's low 3, 6, 8 or 10 bits are all ones. At /1024, 78 ticks therefore span 78 × 1024 cycles.
- R4: With code 3'b110, each falling edge of `ext_pin_i` gives exactly one `tick_o` pulse. The pulse appears three rising clock edges after the pin changes.
- R5: With code 3'b111, each rising edge of `ext_pin_i` gives exactly one `tick_o` pulse, with the same three-edge latency.
- R6: While `rst_n` is low, `tick_o` is 0, the divider is 0 and the synchronizer flops are 0. Counting resumes from divider value 0 after reset.
- R7: `tick_o` in a cycle follows the select code sampled at the preceding clock edge. A code change takes effect one cycle later, with at most one pulse per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 3 | Clock-source select code |
| ext_pin_i | input | 1 | Asynchronous external count pin |
| tick_o | output | 1 | Single-cycle count-enable pulse |

## Verification
`tick_o` is a register. A select code or divider state sampled at one rising edge therefore shows at the output after that same edge. A pin change appears after the third edge: two synchronizer stages, then the edge-detect flop feeding the output register.

The bench runs its own model on each rising edge. The model holds its own divider count and a three-deep record of the pin. It forms the expected pulse from the select code and the state before that edge. The output is compared at the following falling edge, which is the point where the design's value for that edge is settled.

A directed run at /1024 counts the pulses over 78 × 1024 cycles.

// File: rtl/tcps_pkg.sv
package tcps_pkg;
  typedef enum logic [2:0] {
    CS_OFF      = 3'd0,
    CS_DIV1     = 3'd1,
    CS_DIV8     = 3'd2,
    CS_DIV64    = 3'd3,
    CS_DIV256   = 3'd4,
    CS_DIV1024  = 3'd5,
    CS_PIN_FALL = 3'd6,
    CS_PIN_RISE = 3'd7
  } cs_e;

  localparam int DIV_W = 10;
  localparam int NTAP  = 4;

  // log2 of each divider tap, lowest ratio first
  function automatic int tap_log(input int idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/tcps_divider.sv
module tcps_divider
  import tcps_pkg::*;
#(
  parameter int W  = DIV_W,
  parameter int NT = NTAP
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [NT-1:0] tap_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  for (genvar i = 0; i < NT; i++) begin : g_tap
    localparam logic [W-1:0] MASK = W'((1 << tap_log(i)) - 1);
    assign tap_o[i] = ((cnt & MASK) == MASK);

    assert_tap_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tap_o[i] |=> !tap_o[i]);
  end

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == {W{1'b1}}) |=> (cnt == '0));
endmodule

// File: rtl/tcps_pin_sync.sv
module tcps_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], pin_i};
  end

  assign rise_o =  sh[STAGES-1] & ~sh[STAGES];
  assign fall_o = ~sh[STAGES-1] &  sh[STAGES];

  assert_rise_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
  assert_fall_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/tmr_clk_prescaler.sv
module tmr_clk_prescaler
  import tcps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel_i,
  input  logic       ext_pin_i,
  output logic       tick_o
);
  logic [NTAP-1:0] tap;
  logic            pin_rise, pin_fall;
  logic            tick_d;
  cs_e             cs;

  tcps_divider #(.W(DIV_W), .NT(NTAP)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .tap_o (tap)
  );

  tcps_pin_sync #(.STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (ext_pin_i),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  assign cs = cs_e'(sel_i);

  always_comb begin
    case (cs)
      CS_OFF:      tick_d = 1'b0;
      CS_DIV1:     tick_d = 1'b1;
      CS_DIV8:     tick_d = tap[0];
      CS_DIV64:    tick_d = tap[1];
      CS_DIV256:   tick_d = tap[2];
      CS_DIV1024:  tick_d = tap[3];
      CS_PIN_FALL: tick_d = pin_fall;
      CS_PIN_RISE: tick_d = pin_rise;
      default:     tick_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_o <= 1'b0;
    else        tick_o <= tick_d;
  end

  assert_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sel_i) == 3'd0) |-> !tick_o);
  assert_every_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sel_i) == 3'd1) |-> tick_o);
  assert_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sel_i) == 3'd6) |-> (tick_o == $past(pin_fall)));
  assert_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sel_i) == 3'd7) |-> (tick_o == $past(pin_rise)));
  assert_div_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sel_i) == 3'd2) |-> (tick_o == $past(tap[0])));
endmodule

// File: tb/tmr_clk_prescaler_tb.sv
module tmr_clk_prescaler_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       pin = 1'b0;
  logic       tick;

  int n_chk = 0;
  int n_fail = 0;
  bit check_en = 1'b0;
  bit done = 1'b0;

  tmr_clk_prescaler u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (sel),
    .ext_pin_i (pin),
    .tick_o    (tick)
  );

  always #10 clk = ~clk;   // 50 MHz

  // ---------------- reference model ----------------
  int unsigned m_cnt;
  bit p1, p2, p3;
  bit exp_tick;
  logic [2:0] m_sel, m_prev_sel;

  function automatic bit expect_tick(input logic [2:0] s, input int unsigned c,
                                     input bit a, input bit b);
    case (s)
      3'd0: return 1'b0;
      3'd1: return 1'b1;
      3'd2: return (c % 8)    == 7;
      3'd3: return (c % 64)   == 63;
      3'd4: return (c % 256)  == 255;
      3'd5: return (c % 1024) == 1023;
      3'd6: return !a && b;
      default: return a && !b;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] s, input logic [2:0] ps);
    if (s != ps)  return "R7";
    if (s == 3'd0) return "R1";
    if (s == 3'd1) return "R2";
    if (s == 3'd6) return "R4";
    if (s == 3'd7) return "R5";
    return "R3";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; p1 = 0; p2 = 0; p3 = 0; exp_tick = 0;
      m_sel = 3'd0; m_prev_sel = 3'd0;
    end else begin
      exp_tick   = expect_tick(sel, m_cnt, p2, p3);
      m_prev_sel = m_sel;
      m_sel      = sel;
      p3 = p2; p2 = p1; p1 = pin;
      m_cnt = (m_cnt + 1) % 1024;
    end
  end

  always @(negedge clk) begin
    if (check_en && !done) begin
      n_chk++;
      if (tick !== exp_tick) begin
        n_fail++;
        $display("FAIL %s: sel=%0d tick=%0b expected %0b",
                 req_of(m_sel, m_prev_sel), m_sel, tick, exp_tick);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic direct(input bit cond, input string msg, input int act, input int expv);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, expv);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (195000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    int unsigned seed;
    int ticks;
    seed = 32'h5EED_0A17;
    void'($urandom(seed));

    // R6: reset state
    repeat (3) @(negedge clk);
    direct(tick == 1'b0, "R6 tick in reset", int'(tick), 0);
    sel = 3'd1;
    repeat (2) @(negedge clk);
    direct(tick == 1'b0, "R6 tick held by reset with sel 001", int'(tick), 0);
    rst_n = 1'b1;
    check_en = 1'b1;

    // R2 then R7: switch 001 -> 000
    repeat (5) @(negedge clk);
    direct(tick == 1'b1, "R2 tick every cycle", int'(tick), 1);
    sel = 3'd0;
    @(negedge clk);
    direct(tick == 1'b0, "R7 stop one cycle after code change", int'(tick), 0);

    // R1: halted, with pin toggling
    for (int i = 0; i < 40; i++) begin
      pin = ~pin;
      @(negedge clk);
    end

    // R4 / R5 directed single edges
    sel = 3'd7;
    pin = 1'b0;
    repeat (6) @(negedge clk);
    pin = 1'b1;
    ticks = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      ticks += int'(tick);
    end
    direct(ticks == 1, "R5 one tick per rising edge", ticks, 1);
    sel = 3'd6;
    pin = 1'b0;
    ticks = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      ticks += int'(tick);
    end
    direct(ticks == 1, "R4 one tick per falling edge", ticks, 1);

    // random segments: all codes, random pin activity
    for (int seg = 0; seg < 60; seg++) begin
      int len;
      sel = 3'($urandom_range(0, 7));
      len = $urandom_range(20, 300);
      for (int i = 0; i < len; i++) begin
        if ($urandom_range(0, 3) == 0) pin = ~pin;
        @(negedge clk);
      end
    end

    // R6: mid-run reset restarts the divider from 0
    sel = 3'd2;
    rst_n = 1'b0;
    @(negedge clk);
    direct(tick == 1'b0, "R6 tick cleared by reset", int'(tick), 0);
    rst_n = 1'b1;
    ticks = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      ticks += int'(tick);
      if (i < 7) direct(tick == 1'b0, "R6 no early tick after reset", int'(tick), 0);
    end
    direct(ticks == 1, "R6 first /8 tick at eighth cycle", ticks, 1);

    // R3: /1024, 78 ticks over 78*1024 cycles
    sel = 3'd5;
    ticks = 0;
    for (int i = 0; i < 78 * 1024; i++) begin
      @(negedge clk);
      ticks += int'(tick);
    end
    direct(ticks == 78, "R3 /1024 tick count over 79872 cycles", ticks, 78);

    // R3: /64 count
    sel = 3'd3;
    @(negedge clk);
    ticks = 0;
    for (int i = 0; i < 640; i++) begin
      @(negedge clk);
      ticks += int'(tick);
    end
    direct(ticks == 10, "R3 /64 tick count over 640 cycles", ticks, 10);

    finish_run();
  end
endmodule